// File: doc/BRIEF.md
# Asynchronous Serial Receive Channel

This block is one receive channel of an asynchronous serial port. It watches a single serial input line, finds the start of each character, and samples every bit near its centre using a 16x oversampling clock. That oversampling clock comes from a programmable divider of the system clock. The bits are shifted into a shift register. At the end of each character, the completed value moves into a separate holding register. Software can therefore read one character while the next one is still arriving.

Each transfer into the holding register sets a buffer-full indication. This indication is also driven on a dedicated output, which an interrupt controller or a DMA engine can use as a request. The character format is programmable: optional parity with an odd or even select, a 7-bit or 8-bit length, and one or two stop bits. Parity errors, framing errors and overruns are recorded in sticky flags. Software clears a flag by writing zero to it. A character with an error is still delivered, and reception carries on without interruption.

Software reaches the channel through a small register port with four addresses. Reads are combinational. A read of the data address counts as a consuming read only when the read strobe is high.

Top module: `serial_rx_channel`

## Requirements
- R1: Data arrives least significant bit first. Control bit 3 set to 1 selects 7-bit characters, which read back with bit 7 equal to 0. Control bit 3 set to 0 selects 8-bit characters. Address 0 returns the last character received.
- R2: Control bit 0 set to 1 adds a parity bit after the data bits. Control bit 1 set to 1 selects odd parity, and 0 selects even parity. A mismatch sets status bit 1. When parity is disabled, no parity bit is expected and status bit 1 is never set.
- R3: A first stop bit sampled as 0 sets status bit 2. The character is still transferred to address 0.
- R4: Control bit 2 set to 1 configures two stop bits. The character still completes at the centre of the first stop bit, in the same clock cycle as with one stop bit.
- R5: A transfer into the holding register sets status bit 0 and the output `rx_full_req`. A strobed read of address 0 clears both.
- R6: A transfer while status bit 0 is already 1, with no read in that cycle, sets status bit 3. The new character replaces the old one.
- R7: Status bits 1, 2 and 3 are sticky. A later good character does not clear them. Writing 1 to such a bit has no effect, and writing 0 to it clears it.
- R8: A low pulse on the line that ends before the centre of the start bit is ignored. No character results from it, and the next real character is received correctly.
- R9: Address 3 holds the divider value D. One bit time is 16*(D+1) clock cycles.
- R10: A strobed read of address 0 in the same cycle as a transfer returns the old character. Status bit 0 stays 1 afterwards, and status bit 3 is not set.
- R11: A write of 0 to an error flag in the same cycle as a transfer that raises that flag leaves the flag set.
- R12: After reset, status reads 0x00, control reads 0x00, the divider reads 3 and `rx_full_req` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial input line; idles high |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 divider |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a strobed read of address 0 consumes the character |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| rx_full_req | output | 1 | Buffer-full indication, used as an interrupt or DMA request |

## Verification
The transfer of a finished character into the holding register can coincide with software activity in the same cycle. One case is a consuming read of the data register; the other is a write that clears the error flags. To provoke each coincidence, the bench first measures, for one frame format, how many cycles pass from the falling start edge until `rx_full_req` rises. Since the divider restarts at every start edge, that latency is fixed. The bench then places the read or the write exactly on that cycle. For the read, the bench judges the result by the character returned (the old one), by buffer-full staying set, and by the overrun flag staying clear. For the write, it checks that the framing flag survives.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int CHAR_W = 8;
    localparam int REG_W  = 8;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
    localparam logic [1:0] ADDR_DIV  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    // Control register layout, bit 3 down to bit 0
    typedef struct packed {
        logic len7;
        logic two_stop;
        logic par_odd;
        logic par_en;
    } rx_cfg_t;

    // Character handed from the frame sampler to the holding stage
    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_err;
        logic              frm_err;
    } rx_char_t;

    // Parity mismatch: even wants total ones even, odd wants them odd
    function automatic logic parity_mismatch(input logic [CHAR_W-1:0] d,
                                             input logic pbit,
                                             input logic odd);
        return ((^d) ^ pbit) != odd;
    endfunction

endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Counter is held at zero while idle, so every frame starts in phase
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9: with a non-zero divider, ticks never come back to back
    assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0 && $stable(div)) |=> !tick);

endmodule

// File: rtl/srx_frame.sv
module srx_frame
    import srx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rx_in,
    input  logic     tick,
    input  logic     par_en,
    input  logic     par_odd,
    input  logic     len7,
    output logic     run,
    output logic     done,
    output rx_char_t ch
);
    localparam int OS_W  = $clog2(OSR);
    localparam int IDX_W = $clog2(CHAR_W);
    localparam logic [OS_W-1:0]  MID_CNT  = OS_W'(OSR/2 - 1);
    localparam logic [OS_W-1:0]  LAST_CNT = OS_W'(OSR - 1);

    logic [1:0]        sync;
    logic              prev;
    logic              rx_s;
    logic              fall;
    rx_state_e         state;
    logic [OS_W-1:0]   os_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [IDX_W-1:0]  last_idx;
    logic [CHAR_W-1:0] shreg;
    logic [CHAR_W-1:0] data_out;
    logic              par_bit;
    logic              mid_hit;
    logic              full_hit;

    assign rx_s     = sync[1];
    assign fall     = prev && !rx_s;
    assign mid_hit  = tick && (os_cnt == MID_CNT);
    assign full_hit = tick && (os_cnt == LAST_CNT);
    assign last_idx = len7 ? IDX_W'(CHAR_W - 2) : IDX_W'(CHAR_W - 1);
    assign run      = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync <= 2'b11;
            prev <= 1'b1;
        end else begin
            sync <= {sync[0], rx_in};
            prev <= rx_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            os_cnt  <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    os_cnt <= '0;
                    if (fall) state <= ST_START;
                end
                ST_START: begin
                    if (mid_hit) begin
                        os_cnt  <= '0;
                        bit_idx <= '0;
                        state   <= rx_s ? ST_IDLE : ST_DATA;
                    end else if (tick) begin
                        os_cnt <= os_cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (full_hit) begin
                        os_cnt  <= '0;
                        shreg   <= {rx_s, shreg[CHAR_W-1:1]};
                        bit_idx <= bit_idx + 1'b1;
                        if (bit_idx == last_idx) state <= par_en ? ST_PARITY : ST_STOP;
                    end else if (tick) begin
                        os_cnt <= os_cnt + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (full_hit) begin
                        os_cnt  <= '0;
                        par_bit <= rx_s;
                        state   <= ST_STOP;
                    end else if (tick) begin
                        os_cnt <= os_cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    // The frame ends on the first stop bit in every format
                    if (full_hit) begin
                        os_cnt <= '0;
                        state  <= ST_IDLE;
                    end else if (tick) begin
                        os_cnt <= os_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done     = (state == ST_STOP) && full_hit;
    assign data_out = len7 ? {1'b0, shreg[CHAR_W-1:1]} : shreg;

    always_comb begin
        ch.data    = data_out;
        ch.par_err = par_en && parity_mismatch(data_out, par_bit, par_odd);
        ch.frm_err = !rx_s;
    end

    // R4: completion always returns the sampler to idle, never to a second stop bit
    assert_frame_end_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> (state == ST_IDLE));

    // R8: a start bit found high at its centre is dropped
    assert_glitch_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && mid_hit && rx_s) |=> (state == ST_IDLE));

endmodule

// File: rtl/srx_hold.sv
module srx_hold
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_char_t          ch,
    input  logic              rd_data,
    input  logic              wr_stat,
    input  logic [2:0]        keep_mask,
    output logic [CHAR_W-1:0] data_q,
    output logic              full,
    output logic              pe,
    output logic              fe,
    output logic              ov
);
    // keep_mask order: {overrun, framing, parity}; a 0 bit clears that flag
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full   <= 1'b0;
            pe     <= 1'b0;
            fe     <= 1'b0;
            ov     <= 1'b0;
        end else begin
            if (done) data_q <= ch.data;

            if (done)         full <= 1'b1;
            else if (rd_data) full <= 1'b0;

            if (done && ch.par_err)           pe <= 1'b1;
            else if (wr_stat && !keep_mask[0]) pe <= 1'b0;

            if (done && ch.frm_err)           fe <= 1'b1;
            else if (wr_stat && !keep_mask[1]) fe <= 1'b0;

            if (done && full && !rd_data)     ov <= 1'b1;
            else if (wr_stat && !keep_mask[2]) ov <= 1'b0;
        end
    end

    assert_full_on_load_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> full);

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !done) |=> !full);

    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (rst)
        (done && full && !rd_data) |=> ov);

    assert_read_load_no_overrun_R10: assert property (@(posedge clk) disable iff (rst)
        (done && rd_data && !ov && !full) |=> !ov);

    assert_sticky_parity_R7: assert property (@(posedge clk) disable iff (rst)
        (pe && !(wr_stat && !keep_mask[0])) |=> pe);

    assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (done && ch.frm_err) |=> fe);

endmodule

// File: rtl/serial_rx_channel.sv
module serial_rx_channel
    import srx_pkg::*;
#(
    parameter int         OSR       = 16,
    parameter logic [7:0] DIV_RESET = 8'd3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_line,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       rx_full_req
);
    rx_cfg_t           cfg;
    logic [REG_W-1:0]  div_q;
    logic              run;
    logic              tick;
    logic              done;
    rx_char_t          ch;
    logic              rd_data;
    logic              wr_stat;
    logic [CHAR_W-1:0] data_q;
    logic              full, pe, fe, ov;

    assign rd_data = reg_rd && (reg_addr == ADDR_DATA);
    assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            div_q <= DIV_RESET;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_CTRL) cfg   <= rx_cfg_t'(reg_wdata[3:0]);
            if (reg_addr == ADDR_DIV)  div_q <= reg_wdata;
        end
    end

    srx_baud #(.DIV_W(REG_W)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .div  (div_q),
        .tick (tick)
    );

    srx_frame #(.OSR(OSR)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .rx_in   (rx_line),
        .tick    (tick),
        .par_en  (cfg.par_en),
        .par_odd (cfg.par_odd),
        .len7    (cfg.len7),
        .run     (run),
        .done    (done),
        .ch      (ch)
    );

    srx_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .done      (done),
        .ch        (ch),
        .rd_data   (rd_data),
        .wr_stat   (wr_stat),
        .keep_mask (reg_wdata[3:1]),
        .data_q    (data_q),
        .full      (full),
        .pe        (pe),
        .fe        (fe),
        .ov        (ov)
    );

    always_comb begin
        case (reg_addr)
            ADDR_DATA: reg_rdata = data_q;
            ADDR_STAT: reg_rdata = {4'b0, ov, fe, pe, full};
            ADDR_CTRL: reg_rdata = {4'b0, cfg};
            default:   reg_rdata = div_q;
        endcase
    end

    assign rx_full_req = full;

    // R5: the request pin follows the buffer-full state after every load
    assert_req_on_load_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> rx_full_req);

endmodule

// File: tb/test_serial_rx_channel.sv
module test_serial_rx_channel;

    typedef struct packed {
        logic [7:0] div;
        logic [3:0] ctrl;
        logic [7:0] data;
        logic       bad_par;
        logic       bad_stop;
    } vec_t;

    localparam int NV = 12;
    // ctrl: bit0 parity on, bit1 odd, bit2 two stops, bit3 7-bit length
    localparam vec_t VECS [NV] = '{
        '{8'd3, 4'h0, 8'hA5, 1'b0, 1'b0},
        '{8'd3, 4'h1, 8'h3C, 1'b0, 1'b0},
        '{8'd3, 4'h3, 8'h7E, 1'b0, 1'b0},
        '{8'd3, 4'h1, 8'h81, 1'b1, 1'b0},
        '{8'd3, 4'h3, 8'h00, 1'b1, 1'b0},
        '{8'd3, 4'h0, 8'h5A, 1'b0, 1'b1},
        '{8'd3, 4'h8, 8'hD3, 1'b0, 1'b0},
        '{8'd3, 4'hB, 8'h2A, 1'b0, 1'b1},
        '{8'd3, 4'h4, 8'hC3, 1'b0, 1'b0},
        '{8'd5, 4'h5, 8'h96, 1'b1, 1'b1},
        '{8'd1, 4'h0, 8'hFF, 1'b0, 1'b0},
        '{8'd3, 4'h0, 8'h0F, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       rx_full_req;

    int n_vec = 0;
    int n_bad = 0;
    int cur_div = 3;

    always #4 clk = ~clk;

    serial_rx_channel i_serial_rx_channel (
        .clk         (clk),
        .rst         (rst),
        .rx_line     (rx_line),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .rx_full_req (rx_full_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic pop(output logic [7:0] v);
        @(negedge clk);
        reg_addr = 2'd0; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic int bit_clks();
        return 16 * (cur_div + 1);
    endfunction

    // Drives one frame, starting at the current negedge
    task automatic drive_frame(input logic [3:0] ctrl, input logic [7:0] data,
                               input logic bad_par, input logic bad_stop);
        int nbits;
        logic [7:0] d;
        logic p;
        nbits = ctrl[3] ? 7 : 8;
        d = ctrl[3] ? (data & 8'h7F) : data;
        p = ctrl[1] ? ~^d : ^d;
        rx_line = 1'b0;
        repeat (bit_clks()) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            rx_line = d[i];
            repeat (bit_clks()) @(negedge clk);
        end
        if (ctrl[0]) begin
            rx_line = p ^ bad_par;
            repeat (bit_clks()) @(negedge clk);
        end
        rx_line = ~bad_stop;
        repeat (bit_clks()) @(negedge clk);
        if (ctrl[2]) begin
            rx_line = 1'b1;
            repeat (bit_clks()) @(negedge clk);
        end
        rx_line = 1'b1;
    endtask

    task automatic send(input logic [3:0] ctrl, input logic [7:0] data,
                        input logic bad_par, input logic bad_stop);
        @(negedge clk);
        drive_frame(ctrl, data, bad_par, bad_stop);
        repeat (2 * bit_clks()) @(negedge clk);
    endtask

    // Cycles from start edge to the rise of rx_full_req
    task automatic measure(input logic [3:0] ctrl, input logic [7:0] data, output int k);
        @(negedge clk);
        fork
            drive_frame(ctrl, data, 1'b0, 1'b0);
            begin
                k = 0;
                do begin
                    @(negedge clk);
                    k++;
                end while (!rx_full_req && k < 5000);
            end
        join
        repeat (2 * bit_clks()) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired, actual running expected finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] old_v;
        int k1;
        int k2;

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R12: reset state
        peek(2'd1, v); chk("R12 status", v, 8'h00);
        peek(2'd2, v); chk("R12 control", v, 8'h00);
        peek(2'd3, v); chk("R12 divider", v, 8'h03);
        chk("R12 request", {7'b0, rx_full_req}, 8'h00);

        // Vector table: R1 R2 R3 R9
        for (int i = 0; i < NV; i++) begin
            logic [7:0] st_exp;
            logic [7:0] d_exp;
            if (int'(VECS[i].div) != cur_div) begin
                bus_wr(2'd3, VECS[i].div);
                cur_div = int'(VECS[i].div);
            end
            bus_wr(2'd2, {4'b0, VECS[i].ctrl});
            send(VECS[i].ctrl, VECS[i].data, VECS[i].bad_par, VECS[i].bad_stop);
            st_exp = {5'b0, VECS[i].bad_stop, VECS[i].ctrl[0] & VECS[i].bad_par, 1'b1};
            d_exp  = VECS[i].ctrl[3] ? (VECS[i].data & 8'h7F) : VECS[i].data;
            peek(2'd1, v); chk($sformatf("R2 R3 R9 status vec %0d", i), v, st_exp);
            pop(v);        chk($sformatf("R1 data vec %0d", i), v, d_exp);
            bus_wr(2'd1, 8'h00);
        end

        bus_wr(2'd3, 8'd3); cur_div = 3;
        bus_wr(2'd2, 8'h00);

        // R5: read clears buffer-full and the request
        send(4'h0, 8'h44, 1'b0, 1'b0);
        chk("R5 request set", {7'b0, rx_full_req}, 8'h01);
        pop(v);
        peek(2'd1, v); chk("R5 status after read", v, 8'h00);
        chk("R5 request cleared", {7'b0, rx_full_req}, 8'h00);

        // R6: overrun, newest character kept
        send(4'h0, 8'h11, 1'b0, 1'b0);
        send(4'h0, 8'h22, 1'b0, 1'b0);
        peek(2'd1, v); chk("R6 overrun status", v, 8'h09);
        pop(v);        chk("R6 newest data", v, 8'h22);
        bus_wr(2'd1, 8'h00);

        // R7: sticky flags
        bus_wr(2'd2, 8'h01);
        send(4'h1, 8'h31, 1'b1, 1'b0);
        pop(v);
        send(4'h1, 8'h32, 1'b0, 1'b0);
        peek(2'd1, v); chk("R7 flag survives good frame", v, 8'h03);
        pop(v);
        bus_wr(2'd1, 8'hFF);
        peek(2'd1, v); chk("R7 write one keeps flag", v, 8'h02);
        bus_wr(2'd1, 8'h00);
        peek(2'd1, v); chk("R7 write zero clears", v, 8'h00);
        bus_wr(2'd2, 8'h00);

        // R8: short low pulse ignored
        @(negedge clk);
        rx_line = 1'b0;
        repeat (8) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * bit_clks()) @(negedge clk);
        peek(2'd1, v); chk("R8 no character from glitch", v, 8'h00);
        send(4'h0, 8'h66, 1'b0, 1'b0);
        pop(v); chk("R8 next frame intact", v, 8'h66);

        // R4: two stop bits complete at the first stop bit
        measure(4'h0, 8'h33, k1);
        pop(v);
        bus_wr(2'd2, 8'h04);
        measure(4'h4, 8'h33, k2);
        pop(v);
        chk("R4 completion cycle", 8'(k2), 8'(k1));
        bus_wr(2'd2, 8'h00);

        // R10: read lands on the transfer cycle
        send(4'h0, 8'h5C, 1'b0, 1'b0);
        @(negedge clk);
        fork
            drive_frame(4'h0, 8'hC5, 1'b0, 1'b0);
            begin
                repeat (k1 - 1) @(negedge clk);
                reg_addr = 2'd0; reg_rd = 1'b1;
                #1 old_v = reg_rdata;
                @(negedge clk);
                reg_rd = 1'b0;
            end
        join
        repeat (2 * bit_clks()) @(negedge clk);
        chk("R10 read returns old character", old_v, 8'h5C);
        peek(2'd1, v); chk("R10 full kept, no overrun", v, 8'h01);
        pop(v);        chk("R10 new character", v, 8'hC5);

        // R11: clear write lands on a framing-error transfer
        @(negedge clk);
        fork
            drive_frame(4'h0, 8'h77, 1'b0, 1'b1);
            begin
                repeat (k1 - 1) @(negedge clk);
                reg_addr = 2'd1; reg_wdata = 8'h00; reg_wr = 1'b1;
                @(negedge clk);
                reg_wr = 1'b0;
            end
        join
        repeat (2 * bit_clks()) @(negedge clk);
        peek(2'd1, v); chk("R11 set wins over clear", v, 8'h05);

        finish_run();
    end

endmodule